// File: doc/BRIEF.md
# Maskable Interrupt Pin Generator

This block merges up to 32 interrupt sources into a single device interrupt pin. The sources are endpoint events and bus events: start of frame, missed start of frame, end of transfer, suspend, resume and bus reset. Each source has a sticky pending flag. An event strobe sets the flag, and it stays set until the host writes a one to its clear bit. A 32-bit enable word decides which pending flags may reach the pin.

The pin has two signalling modes and a selectable polarity. In level mode it is active while at least one enabled flag is pending. In pulse mode it gives one pulse of a fixed length, 8 clocks by default (about 166 ns at 48 MHz), each time an enabled pending condition newly appears. An event that arrives while a pulse is running is remembered, and it gets its own pulse after one inactive cycle.

The bus reset strobe marks its own source as pending and does not touch the enable word, the mode or the polarity. Only a power-on reset returns these settings to their defaults. The host register interface and the event detectors lie outside the block.

Top module: `irq_pin_gen`

## Requirements
- R1: After power-on reset the enable word reads 0, level mode (mode bit 0) and active-low polarity (polarity bit 0) are selected, all pending flags read 0, and the pin is high (inactive).
- R2: A one on `evt_i[i]` sets `pend_o[i]` at the next clock edge. The flag stays set until a cycle with `clr_i[i]` = 1 and no event on that bit. If the event and the clear arrive in the same cycle, the event wins.
- R3: A source whose enable bit is 0 still records its pending flag, but it never makes the pin active in either mode.
- R4: In level mode the pin is active from the second clock edge after an enabled flag becomes pending. It is inactive again from the second edge after the last enabled pending flag is cleared.
- R5: In pulse mode, a newly appearing enabled pending condition makes the pin active for exactly PULSE_CYC (8) consecutive cycles, starting at the second edge after the event.
- R6: In pulse mode, a flag that stays pending gives no further pulses. Several sources that become pending in the same cycle give one pulse.
- R7: In pulse mode, a new condition that appears while a pulse is active is latched. It gives a second full pulse that follows exactly one inactive cycle.
- R8: Polarity bit 1 drives the pin high when active. Polarity bit 0 drives it low when active.
- R9: A `bus_rst_i` strobe sets pending flag 31 (the bus-reset source) and leaves the enable word, the mode bit and the polarity bit unchanged.
- R10: With `cfg_we_i` high, the enable word, mode bit and polarity bit are loaded together at the clock edge and read back on `en_o`, `pulse_o` and `pol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock (48 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| evt_i | input | 32 | Raw event strobes, one per source |
| bus_rst_i | input | 1 | Bus reset strobe, raises pending flag 31 |
| clr_i | input | 32 | Write-one-to-clear for pending flags |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 32 | Enable word to write |
| cfg_pulse_i | input | 1 | Mode to write: 0 level, 1 pulse |
| cfg_pol_i | input | 1 | Polarity to write: 0 active low, 1 active high |
| en_o | output | 32 | Current enable word |
| pulse_o | output | 1 | Current mode bit |
| pol_o | output | 1 | Current polarity bit |
| pend_o | output | 32 | Pending flags |
| irq_pin_o | output | 1 | Device interrupt pin |

## Verification
The embedded assertions check, on every cycle, the parts that are local to one step. Pending flags never drop without a clear, and an event always lands in its flag. A bus reset never disturbs the settings. A pulse always ends in a single gap cycle, and an event that arrives during a pulse is always latched. Other properties need whole scenarios compared against the bench's reference model: the exact 8-cycle pulse length, the missing retrigger for a flag that stays pending, one pulse for simultaneous sources, the two-edge level latency, and silence from disabled sources.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_PULSE = 2'd1,
    PS_GAP   = 2'd2
  } pulse_st_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             any_o,
  output logic             new_o
);
  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] prev_q, prev_d;
  logic [N_SRC-1:0] rise;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_comb begin
      pend_d[i] = evt_i[i] | (pend_q[i] & ~clr_i[i]);
      prev_d[i] = pend_q[i] & en_i[i];
      rise[i]   = pend_q[i] & en_i[i] & ~prev_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  assign pend_o = pend_q;
  assign any_o  = |(pend_q & en_i);
  assign new_o  = |rise;

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

  // R2
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_pulse_fsm.sv
module irq_pulse_fsm
  import irq_pkg::*;
#(
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic new_i,
  output logic act_o
);
  localparam int CNT_W = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

  pulse_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    req_d = req_q;
    if (!run_i) begin
      st_d  = PS_IDLE;
      cnt_d = '0;
      req_d = 1'b0;
    end else begin
      unique case (st_q)
        PS_IDLE: begin
          if (new_i) begin
            st_d  = PS_PULSE;
            cnt_d = CNT_LAST;
          end
        end
        PS_PULSE: begin
          if (new_i) req_d = 1'b1;
          if (cnt_q == '0) st_d = PS_GAP;
          else             cnt_d = cnt_q - 1'b1;
        end
        PS_GAP: begin
          req_d = 1'b0;
          if (req_q || new_i) begin
            st_d  = PS_PULSE;
            cnt_d = CNT_LAST;
          end else begin
            st_d = PS_IDLE;
          end
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign act_o = (st_q == PS_PULSE);

  // R5
  pulse_end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && st_q == PS_PULSE && cnt_q == '0) |=> (st_q == PS_GAP));

  // R7
  gap_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_GAP) |-> $past(st_q == PS_PULSE));

  // R7
  latch_during_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && st_q == PS_PULSE && new_i) |=> (req_q || !run_i || st_q == PS_PULSE));
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen #(
  parameter int N_SRC     = 32,
  parameter int PULSE_CYC = 8,
  parameter int RST_SRC   = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             bus_rst_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             cfg_we_i,
  input  logic [N_SRC-1:0] cfg_en_i,
  input  logic             cfg_pulse_i,
  input  logic             cfg_pol_i,
  output logic [N_SRC-1:0] en_o,
  output logic             pulse_o,
  output logic             pol_o,
  output logic [N_SRC-1:0] pend_o,
  output logic             irq_pin_o
);
  localparam logic [N_SRC-1:0] RST_MASK = N_SRC'(1) << RST_SRC;

  logic             rst_sn;
  logic [N_SRC-1:0] en_q, en_d;
  logic             pulse_q, pulse_d;
  logic             pol_q, pol_d;
  logic             lvl_q, lvl_d;
  logic [N_SRC-1:0] evt_all;
  logic             any_en, new_en, pulse_act, irq_act;

  irq_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  assign evt_all = evt_i | (bus_rst_i ? RST_MASK : '0);

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_sn),
    .evt_i  (evt_all),
    .clr_i  (clr_i),
    .en_i   (en_q),
    .pend_o (pend_o),
    .any_o  (any_en),
    .new_o  (new_en)
  );

  irq_pulse_fsm #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_sn),
    .run_i (pulse_q),
    .new_i (new_en),
    .act_o (pulse_act)
  );

  always_comb begin
    en_d    = en_q;
    pulse_d = pulse_q;
    pol_d   = pol_q;
    if (cfg_we_i) begin
      en_d    = cfg_en_i;
      pulse_d = cfg_pulse_i;
      pol_d   = cfg_pol_i;
    end
    lvl_d = any_en;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q    <= '0;
      pulse_q <= 1'b0;
      pol_q   <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      pulse_q <= pulse_d;
      pol_q   <= pol_d;
      lvl_q   <= lvl_d;
    end
  end

  assign irq_act   = pulse_q ? pulse_act : lvl_q;
  assign irq_pin_o = pol_q ? irq_act : ~irq_act;
  assign en_o      = en_q;
  assign pulse_o   = pulse_q;
  assign pol_o     = pol_q;

  // R9
  bus_rst_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rst_i && !cfg_we_i) |=> ($stable(en_q) && $stable(pulse_q) && $stable(pol_q)));

  // R3
  off_src_silent_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (en_q == '0 && $past(en_q) == '0 && !pulse_q && !$past(pulse_q)) |-> !irq_act);
endmodule

// File: tb/test_irq_pin_gen.sv
module test_irq_pin_gen;
  localparam int CLK_PERIOD = 20;
  localparam int PW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        bus_rst_i = 1'b0;
  logic [31:0] clr_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_en_i = '0;
  logic        cfg_pulse_i = 1'b0;
  logic        cfg_pol_i = 1'b0;
  logic [31:0] en_o, pend_o;
  logic        pulse_o, pol_o, irq_pin_o;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    cmp_on = 1'b0;
  string cur_req = "R1";

  irq_pin_gen i_irq_pin_gen (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_rst_i(bus_rst_i), .clr_i(clr_i),
    .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_pulse_i(cfg_pulse_i), .cfg_pol_i(cfg_pol_i),
    .en_o(en_o), .pulse_o(pulse_o), .pol_o(pol_o), .pend_o(pend_o), .irq_pin_o(irq_pin_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_pend, m_prev, m_en;
  logic        m_pulse, m_pol, m_lvl, m_gap, m_req;
  int          m_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0; m_prev <= '0; m_en <= '0;
      m_pulse <= 0; m_pol <= 0; m_lvl <= 0; m_gap <= 0; m_req <= 0; m_rem <= 0;
    end else begin
      logic [31:0] ev;
      bit nw;
      ev = evt_i | (bus_rst_i ? 32'h8000_0000 : 32'h0);
      nw = |(m_pend & m_en & ~m_prev);
      if (!m_pulse) begin
        m_rem <= 0; m_gap <= 0; m_req <= 0;
      end else if (m_rem > 0) begin
        m_rem <= m_rem - 1;
        if (m_rem == 1) m_gap <= 1;
        if (nw) m_req <= 1;
      end else if (m_gap) begin
        m_gap <= 0;
        m_req <= 0;
        if (m_req || nw) m_rem <= PW;
      end else if (nw) begin
        m_rem <= PW;
      end
      m_lvl  <= |(m_pend & m_en);
      m_prev <= m_pend & m_en;
      m_pend <= ev | (m_pend & ~clr_i);
      if (cfg_we_i) begin
        m_en <= cfg_en_i; m_pulse <= cfg_pulse_i; m_pol <= cfg_pol_i;
      end
    end
  end

  function automatic bit model_pin();
    bit a;
    a = m_pulse ? (m_rem > 0) : m_lvl;
    return m_pol ? a : !a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check(cur_req, {31'b0, irq_pin_o}, {31'b0, model_pin()}, "pin vs model");
      check(cur_req, pend_o, m_pend, "pending vs model");
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end

  task automatic cfg(input logic [31:0] en, input bit pm, input bit pl);
    @(negedge clk);
    cfg_we_i = 1; cfg_en_i = en; cfg_pulse_i = pm; cfg_pol_i = pl;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_i = '1;
    @(negedge clk); clr_i = '0;
    repeat (12) @(negedge clk);
  endtask

  // drives e0 in cycle 0 and e1 in cycle t1; counts active samples, pulses and gap
  task automatic window(input logic [31:0] e0, input int t1, input logic [31:0] e1, input int n,
                        output int act, output int pulses, output int gap);
    bit prev_a, a;
    int low_run;
    act = 0; pulses = 0; gap = -1; prev_a = 0; low_run = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      a = pol_o ? irq_pin_o : !irq_pin_o;
      if (a) act++;
      if (a && !prev_a) begin
        pulses++;
        if (pulses == 2) gap = low_run;
      end
      if (!a) low_run++; else low_run = 0;
      prev_a = a;
      evt_i = (c == 0) ? e0 : (c == t1) ? e1 : 32'h0;
    end
    evt_i = '0;
  endtask

  initial begin
    int act, pl, gp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {31'b0, irq_pin_o}, 32'h1, "pin in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", en_o, 32'h0, "enable after reset");
    check("R1", {30'b0, pulse_o, pol_o}, 32'h0, "mode/polarity after reset");
    check("R1", pend_o, 32'h0, "pending after reset");
    check("R1", {31'b0, irq_pin_o}, 32'h1, "pin after reset");
    cmp_on = 1;

    cur_req = "R10";
    cfg(32'h0000_000F, 0, 0);
    check("R10", en_o, 32'h0000_000F, "enable readback");
    check("R10", {30'b0, pulse_o, pol_o}, 32'h0, "mode/polarity readback");

    cur_req = "R2";
    window(32'h1, -1, 0, 6, act, pl, gp);
    check("R2", pend_o & 32'h1, 32'h1, "flag sticky");
    @(negedge clk); evt_i = 32'h2; clr_i = 32'h3;
    @(negedge clk); evt_i = 0; clr_i = 0;
    check("R2", pend_o & 32'h3, 32'h2, "set wins over clear, bit0 cleared");
    clear_all();
    check("R2", pend_o, 32'h0, "all cleared");

    cur_req = "R3";
    window(32'h0010_0000, -1, 0, 12, act, pl, gp);
    check("R3", act, 0, "disabled source level mode");
    check("R3", pend_o & 32'h0010_0000, 32'h0010_0000, "disabled flag recorded");
    clear_all();

    cur_req = "R4";
    window(32'h4, -1, 0, 10, act, pl, gp);
    check("R4", act, 8, "level active samples");
    check("R4", {31'b0, irq_pin_o}, 32'h0, "level pin low while pending");
    @(negedge clk); clr_i = 32'h4;
    @(negedge clk); clr_i = 0;
    check("R4", {31'b0, irq_pin_o}, 32'h0, "pin one edge after clear");
    @(negedge clk);
    check("R4", {31'b0, irq_pin_o}, 32'h1, "pin two edges after clear");

    cur_req = "R8";
    cfg(32'h0000_000F, 0, 1);
    check("R8", {31'b0, irq_pin_o}, 32'h0, "active-high idle");
    window(32'h8, -1, 0, 4, act, pl, gp);
    check("R8", {31'b0, irq_pin_o}, 32'h1, "active-high asserted");
    clear_all();

    cur_req = "R5";
    cfg(32'h0000_000F, 1, 1);
    window(32'h1, -1, 0, 20, act, pl, gp);
    check("R5", act, PW, "pulse width");
    check("R5", pl, 1, "pulse count");
    cur_req = "R6";
    window(32'h0, -1, 0, 20, act, pl, gp);
    check("R6", act, 0, "no retrigger while pending");
    clear_all();
    window(32'h6, -1, 0, 20, act, pl, gp);
    check("R6", pl, 1, "simultaneous sources one pulse");
    check("R6", act, PW, "simultaneous width");
    clear_all();

    cur_req = "R7";
    window(32'h1, 3, 32'h2, 30, act, pl, gp);
    check("R7", pl, 2, "second pulse");
    check("R7", gp, 1, "gap cycles");
    check("R7", act, 2*PW, "both pulses full");
    clear_all();

    cur_req = "R3";
    window(32'h0000_0100, -1, 0, 15, act, pl, gp);
    check("R3", act, 0, "disabled source pulse mode");
    clear_all();

    cur_req = "R9";
    cfg(32'h8000_000F, 1, 0);
    @(negedge clk); bus_rst_i = 1;
    @(negedge clk); bus_rst_i = 0;
    check("R9", en_o, 32'h8000_000F, "enable kept");
    check("R9", {30'b0, pulse_o, pol_o}, 32'h2, "mode/polarity kept");
    check("R9", pend_o & 32'h8000_0000, 32'h8000_0000, "bus reset flag");
    window(32'h0, -1, 0, 14, act, pl, gp);
    check("R9", pl, 1, "bus reset source pulses");
    clear_all();

    finish_run();
  end
endmodule